// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Controller

This block is the control skeleton of an in-order processor pipeline with six stages: fetch, decode, operand-address calculation, operand fetch, execute and write-back. It carries instruction descriptors through the stages and does no arithmetic or memory access. Each descriptor holds a tag, one destination register, two source registers, a branch-taken flag and a branch target. The block takes at most one new instruction per cycle, and a pipeline register sits between each pair of stages.

The block reports which stages hold a valid instruction. It pulses a retire strobe with the tag of each instruction leaving write-back. Read-after-write dependencies are caught in operand fetch, and the front of the pipe stalls until the producing instruction has left write-back. A taken branch resolves in execute: it raises a redirect strobe carrying the target and discards every younger instruction. The instruction source watches the ready output. On a redirect it drops whatever it was presenting and continues from the target.

Top module: `pipe6_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stageValid` is 0, `retireValid` and `redirectValid` are 0, and `inReady` is 1.
- R2: A descriptor presented with `inValid` high in a cycle where `inReady` is high enters fetch (`stageValid` bit 0) on the next clock edge. A cycle with `inValid` low puts a bubble into fetch.
- R3: With no hazard, an instruction moves one stage per cycle and retires 6 cycles after the cycle in which it was accepted. Back-to-back, N instructions occupy the pipe from the first fetch cycle to the last retire cycle in exactly 6+N-1 cycles, so 9 instructions take 14 cycles. After six back-to-back accepts, `stageValid` is all ones (bit 0 is fetch, bit 5 is write-back).
- R4: When operand fetch holds a valid instruction and either of its source registers equals the destination of a valid instruction in execute or write-back, `inReady` is low. Fetch through operand fetch keep their contents, and execute receives a bubble on the next edge.
- R5: The stall lasts until the producer has left write-back. A consumer right behind its producer retires 3 cycles after the producer (2 stall cycles). A consumer with one independent instruction between them also retires 3 cycles after the producer (1 stall cycle).
- R6: When a valid instruction with the taken flag set is in execute, `redirectValid` is high for that one cycle with `redirectTarget` equal to its target, and `inReady` is low. On the next edge fetch through execute become empty (`stageValid` = 6'b100000 when nothing else was in flight), and the branch itself goes on to retire.
- R7: A taken branch in execute takes priority over a dependency stall in the same cycle. The redirect is not delayed, and the stalled instruction is discarded.
- R8: Retirement is in acceptance order. `retireValid` pulses once per surviving instruction with `retireTag` equal to its tag. Bubbles and discarded instructions never retire.
- R9: An instruction with the taken flag clear never causes a redirect, and its younger neighbours retire with the normal 6-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Descriptor present |
| inTag | input | TAG_W | Instruction tag |
| inDst | input | REG_W | Destination register |
| inSrcA | input | REG_W | First source register |
| inSrcB | input | REG_W | Second source register |
| inTaken | input | 1 | Branch resolves as taken |
| inTarget | input | PC_W | Branch target |
| inReady | output | 1 | Descriptor is accepted this cycle if valid |
| stageValid | output | 6 | Per-stage occupancy, bit 0 fetch to bit 5 write-back |
| retireValid | output | 1 | An instruction leaves write-back this cycle |
| retireTag | output | TAG_W | Tag of the retiring instruction |
| redirectValid | output | 1 | Taken branch resolved; fetch restarts |
| redirectTarget | output | PC_W | Restart address |

## Verification
The assertions assume that reset is held for at least one clock edge, so that the stage registers start empty and no retire or redirect appears before an instruction has gone through. They also assume that the instruction source holds its descriptor while `inReady` is low. The bench keeps to this: it changes its inputs only after an edge, and only once its descriptor has been accepted or dropped on a redirect. The random stimulus draws registers from a set of four, so dependencies are frequent, and it sets the taken flag on about one instruction in eight. This exercises stalls, flushes and their overlap.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;
  localparam int NUM_STAGES = 6;
  localparam int FE_IDX = 0;
  localparam int FO_IDX = 3;
  localparam int EX_IDX = 4;
  localparam int WB_IDX = 5;

  typedef struct packed {
    logic acceptIn;
    logic holdFront;
    logic flushFront;
    logic bubbleEx;
  } ctrlStrobe_t;
endpackage

// File: rtl/pipe6_control.sv
module pipe6_control
  import pipe6_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hazard,
  input  logic        exBranch,
  output ctrlStrobe_t ctrl
);
  logic stallNow;

  // A resolving taken branch overrides any stall: the stalled slot dies anyway.
  assign stallNow = hazard && !exBranch;

  always_comb begin
    ctrl.holdFront  = stallNow;
    ctrl.flushFront = exBranch;
    ctrl.bubbleEx   = stallNow || exBranch;
    ctrl.acceptIn   = !stallNow && !exBranch;
  end

  // R6: the bubble behind a resolving branch means no back-to-back redirect
  redirect_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    exBranch |=> !exBranch);

  // R7
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hazard && exBranch) |=> !exBranch);
endmodule

// File: rtl/pipe6_datapath.sv
module pipe6_datapath
  import pipe6_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int REG_W = 5,
  parameter int PC_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           ctrl,
  input  logic                  inValid,
  input  logic [TAG_W-1:0]      inTag,
  input  logic [REG_W-1:0]      inDst,
  input  logic [REG_W-1:0]      inSrcA,
  input  logic [REG_W-1:0]      inSrcB,
  input  logic                  inTaken,
  input  logic [PC_W-1:0]       inTarget,
  output logic [NUM_STAGES-1:0] stageValid,
  output logic                  hazard,
  output logic                  exBranch,
  output logic [PC_W-1:0]       exTarget,
  output logic                  retireValid,
  output logic [TAG_W-1:0]      retireTag
);
  localparam int SRC_DEPTH = FO_IDX + 1;
  localparam int BR_DEPTH  = EX_IDX + 1;
  localparam int NUM_PROD  = NUM_STAGES - EX_IDX;

  logic [NUM_STAGES-1:0] vld, vldNext, loadEn;
  logic [TAG_W-1:0] tagQ   [NUM_STAGES];
  logic [REG_W-1:0] dstQ   [NUM_STAGES];
  logic [REG_W-1:0] srcAQ  [SRC_DEPTH];
  logic [REG_W-1:0] srcBQ  [SRC_DEPTH];
  logic             takenQ [BR_DEPTH];
  logic [PC_W-1:0]  tgtQ   [BR_DEPTH];
  logic [NUM_PROD-1:0] prodMatch;

  always_comb begin
    vldNext = vld;
    loadEn  = '1;
    if (ctrl.acceptIn)        vldNext[FE_IDX] = inValid;
    else if (ctrl.flushFront) vldNext[FE_IDX] = 1'b0;
    loadEn[FE_IDX] = ctrl.acceptIn;
    for (int s = FE_IDX + 1; s <= FO_IDX; s++) begin
      if (ctrl.flushFront)      vldNext[s] = 1'b0;
      else if (!ctrl.holdFront) vldNext[s] = vld[s-1];
      loadEn[s] = !ctrl.holdFront;
    end
    vldNext[EX_IDX] = ctrl.bubbleEx ? 1'b0 : vld[FO_IDX];
    vldNext[WB_IDX] = vld[EX_IDX];
  end

  always_ff @(posedge clk) begin
    if (!rstN) vld <= '0;
    else       vld <= vldNext;
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    if (s == FE_IDX) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tagQ[s] <= '0; dstQ[s] <= '0; srcAQ[s] <= '0; srcBQ[s] <= '0;
          takenQ[s] <= 1'b0; tgtQ[s] <= '0;
        end else if (loadEn[s]) begin
          tagQ[s] <= inTag; dstQ[s] <= inDst; srcAQ[s] <= inSrcA; srcBQ[s] <= inSrcB;
          takenQ[s] <= inTaken; tgtQ[s] <= inTarget;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tagQ[s] <= '0; dstQ[s] <= '0;
        end else if (loadEn[s]) begin
          tagQ[s] <= tagQ[s-1]; dstQ[s] <= dstQ[s-1];
        end
      end
      if (s < SRC_DEPTH) begin : g_src
        always_ff @(posedge clk) begin
          if (!rstN) begin
            srcAQ[s] <= '0; srcBQ[s] <= '0;
          end else if (loadEn[s]) begin
            srcAQ[s] <= srcAQ[s-1]; srcBQ[s] <= srcBQ[s-1];
          end
        end
      end
      if (s < BR_DEPTH) begin : g_br
        always_ff @(posedge clk) begin
          if (!rstN) begin
            takenQ[s] <= 1'b0; tgtQ[s] <= '0;
          end else if (loadEn[s]) begin
            takenQ[s] <= takenQ[s-1]; tgtQ[s] <= tgtQ[s-1];
          end
        end
      end
    end
  end

  // Dependency comparators: operand fetch against each producer stage.
  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    assign prodMatch[p] = vld[EX_IDX+p] &&
      ((dstQ[EX_IDX+p] == srcAQ[FO_IDX]) || (dstQ[EX_IDX+p] == srcBQ[FO_IDX]));
  end

  assign hazard      = vld[FO_IDX] && (|prodMatch);
  assign exBranch    = vld[EX_IDX] && takenQ[EX_IDX];
  assign exTarget    = tgtQ[EX_IDX];
  assign stageValid  = vld;
  assign retireValid = vld[WB_IDX];
  assign retireTag   = tagQ[WB_IDX];

  // R4
  front_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdFront |=> (vld[FO_IDX:FE_IDX] == $past(vld[FO_IDX:FE_IDX]) &&
                        tagQ[FO_IDX] == $past(tagQ[FO_IDX])));

  // R4
  ex_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.bubbleEx |=> !vld[EX_IDX]);

  // R6
  front_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flushFront |=> (vld[EX_IDX:FE_IDX] == '0));

  // R8
  retire_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |-> $past(vld[EX_IDX]));

  // R3
  retire_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |-> (retireTag == $past(tagQ[EX_IDX])));
endmodule

// File: rtl/pipe6_ctrl.sv
module pipe6_ctrl
  import pipe6_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int REG_W = 5,
  parameter int PC_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [TAG_W-1:0]      inTag,
  input  logic [REG_W-1:0]      inDst,
  input  logic [REG_W-1:0]      inSrcA,
  input  logic [REG_W-1:0]      inSrcB,
  input  logic                  inTaken,
  input  logic [PC_W-1:0]       inTarget,
  output logic                  inReady,
  output logic [NUM_STAGES-1:0] stageValid,
  output logic                  retireValid,
  output logic [TAG_W-1:0]      retireTag,
  output logic                  redirectValid,
  output logic [PC_W-1:0]       redirectTarget
);
  ctrlStrobe_t ctrl;
  logic hazard, exBranch;
  logic [PC_W-1:0] exTarget;

  pipe6_control u_control (
    .clk(clk), .rstN(rstN), .hazard(hazard), .exBranch(exBranch), .ctrl(ctrl)
  );

  pipe6_datapath #(.TAG_W(TAG_W), .REG_W(REG_W), .PC_W(PC_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inValid(inValid), .inTag(inTag), .inDst(inDst), .inSrcA(inSrcA),
    .inSrcB(inSrcB), .inTaken(inTaken), .inTarget(inTarget),
    .stageValid(stageValid), .hazard(hazard), .exBranch(exBranch),
    .exTarget(exTarget), .retireValid(retireValid), .retireTag(retireTag)
  );

  assign inReady        = ctrl.acceptIn;
  assign redirectValid  = exBranch;
  assign redirectTarget = exTarget;
endmodule

// File: tb/pipe6_ctrl_bench.sv
module pipe6_ctrl_bench;
  localparam int TAG_W = 8;
  localparam int REG_W = 5;
  localparam int PC_W  = 16;
  localparam int DEPTH = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [TAG_W-1:0] inTag = '0;
  logic [REG_W-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic inTaken = 1'b0;
  logic [PC_W-1:0] inTarget = '0;
  logic inReady, retireValid, redirectValid;
  logic [5:0] stageValid;
  logic [TAG_W-1:0] retireTag;
  logic [PC_W-1:0] redirectTarget;

  always #5 clk = ~clk;

  pipe6_ctrl u_pipe6_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag), .inDst(inDst),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inTaken(inTaken), .inTarget(inTarget),
    .inReady(inReady), .stageValid(stageValid), .retireValid(retireValid),
    .retireTag(retireTag), .redirectValid(redirectValid),
    .redirectTarget(redirectTarget)
  );

  typedef struct {
    logic [TAG_W-1:0] tag;
    bit               taken;
    logic [PC_W-1:0]  tgt;
    bit               resolved;
  } ent_t;

  ent_t sbQ[$];
  int errCnt = 0;
  int chkCnt = 0;
  int cycle = 0;
  bit done = 1'b0;
  int accCycle [256];
  int retCycle [256];
  logic [5:0] occAt [int];
  int redirCount = 0;
  int lastRedirCycle = -1;

  function automatic int idealCycles(input int n);
    return DEPTH + n - 1;
  endfunction

  function automatic int expRetire(input int acc, input int stalls);
    return acc + DEPTH + stalls;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(output bit acc, output bit redir);
    int idx;
    @(negedge clk);
    cycle++;
    occAt[cycle] = stageValid;
    redir = redirectValid;
    if (retireValid) begin
      retCycle[retireTag] = cycle;
      if (sbQ.size() == 0) check(1'b0, "R8", "retire with nothing in flight", retireTag, 0);
      else begin
        check(retireTag == sbQ[0].tag, "R8", "retire order tag", retireTag, sbQ[0].tag);
        void'(sbQ.pop_front());
      end
    end
    if (redirectValid) begin
      redirCount++;
      lastRedirCycle = cycle;
      check(!inReady, "R6", "inReady during redirect", inReady, 0);
      idx = -1;
      for (int i = 0; i < sbQ.size(); i++)
        if (sbQ[i].taken && !sbQ[i].resolved) begin idx = i; break; end
      if (idx < 0) check(1'b0, "R9", "redirect without taken branch", 1, 0);
      else begin
        check(redirectTarget == sbQ[idx].tgt, "R6", "redirect target",
              redirectTarget, sbQ[idx].tgt);
        sbQ[idx].resolved = 1'b1;
        while (sbQ.size() > idx + 1) void'(sbQ.pop_back());
      end
    end
    acc = inValid && inReady;
    if (acc) begin
      ent_t e;
      e.tag = inTag; e.taken = inTaken; e.tgt = inTarget; e.resolved = 1'b0;
      sbQ.push_back(e);
      accCycle[inTag] = cycle;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    bit a, r;
    inValid = 1'b0;
    for (int i = 0; i < n; i++) step(a, r);
  endtask

  task automatic send(input logic [TAG_W-1:0] t, input logic [REG_W-1:0] d,
                      input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                      input bit tk, input logic [PC_W-1:0] tg, output bit accepted);
    bit a, r;
    inValid = 1'b1; inTag = t; inDst = d; inSrcA = sa; inSrcB = sb;
    inTaken = tk; inTarget = tg;
    a = 1'b0; r = 1'b0;
    while (!a && !r) step(a, r);
    accepted = a;
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 0);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt + 1);
      $finish;
    end
  end

  initial begin
    bit ok;
    int first, last, rc;
    for (int i = 0; i < 256; i++) begin accCycle[i] = -1; retCycle[i] = -1; end
    void'($urandom(32'h5eed_0042));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(stageValid == 6'b0, "R1", "stageValid in reset", stageValid, 0);
    check(!retireValid && !redirectValid, "R1", "strobes in reset",
          {retireValid, redirectValid}, 0);
    check(inReady, "R1", "inReady in reset", inReady, 1);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(stageValid == 6'b0 && inReady, "R1", "state after reset",
          {inReady, stageValid}, 7'h40);
    @(posedge clk); #1;

    // R2: one instruction, then bubbles
    send(8'h01, 5'd1, 5'd20, 5'd21, 1'b0, '0, ok);
    idle(1);
    check(occAt[cycle] == 6'b000001, "R2", "single entry in fetch", occAt[cycle], 1);
    idle(1);
    check(occAt[cycle] == 6'b000010, "R2", "bubble behind single entry", occAt[cycle], 2);
    idle(8);
    check(retCycle[8'h01] == expRetire(accCycle[8'h01], 0), "R3", "single latency",
          retCycle[8'h01], expRetire(accCycle[8'h01], 0));

    // R3: nine independent back to back, fill and drain
    for (int i = 0; i < 9; i++) begin
      send(8'h10 + 8'(i), 5'(i + 1), 5'd20, 5'd21, 1'b0, '0, ok);
      if (i == 6)
        check(occAt[cycle] == 6'h3f, "R3", "full occupancy", occAt[cycle], 6'h3f);
    end
    idle(10);
    first = accCycle[8'h10];
    last  = retCycle[8'h18];
    check(last - first == idealCycles(9), "R3", "nine instructions cycles",
          last - first, idealCycles(9));
    for (int i = 0; i < 9; i++) begin
      rc = retCycle[8'h10 + i];
      check(rc == expRetire(accCycle[8'h10 + i], 0), "R3", "per-entry latency",
            rc, expRetire(accCycle[8'h10 + i], 0));
    end

    // R4 R5: consumer right behind producer (source A)
    send(8'h20, 5'd7, 5'd20, 5'd21, 1'b0, '0, ok);
    send(8'h21, 5'd8, 5'd7, 5'd21, 1'b0, '0, ok);
    send(8'h22, 5'd9, 5'd20, 5'd21, 1'b0, '0, ok);
    idle(14);
    check(retCycle[8'h21] == retCycle[8'h20] + 3, "R5", "adjacent RAW retire gap",
          retCycle[8'h21] - retCycle[8'h20], 3);
    check(retCycle[8'h22] == retCycle[8'h21] + 1, "R4", "follower after stall",
          retCycle[8'h22] - retCycle[8'h21], 1);
    check(accCycle[8'h22] == accCycle[8'h21] + 1, "R4", "follower accepted before hazard",
          accCycle[8'h22] - accCycle[8'h21], 1);

    // R4 R5: one independent between (source B)
    send(8'h30, 5'd10, 5'd20, 5'd21, 1'b0, '0, ok);
    send(8'h31, 5'd11, 5'd20, 5'd21, 1'b0, '0, ok);
    send(8'h32, 5'd12, 5'd22, 5'd10, 1'b0, '0, ok);
    idle(14);
    check(retCycle[8'h31] == retCycle[8'h30] + 1, "R5", "independent not delayed",
          retCycle[8'h31] - retCycle[8'h30], 1);
    check(retCycle[8'h32] == retCycle[8'h30] + 3, "R5", "gap-one RAW retire gap",
          retCycle[8'h32] - retCycle[8'h30], 3);

    // R9: branch with taken clear
    rc = redirCount;
    send(8'h40, 5'd13, 5'd20, 5'd21, 1'b0, 16'hbeef, ok);
    for (int i = 1; i < 6; i++) send(8'h40 + 8'(i), 5'(13 + i), 5'd20, 5'd21, 1'b0, '0, ok);
    idle(12);
    check(redirCount == rc, "R9", "no redirect for not-taken", redirCount, rc);
    check(retCycle[8'h45] == expRetire(accCycle[8'h45], 0), "R9", "younger latency",
          retCycle[8'h45], expRetire(accCycle[8'h45], 0));

    // R6 R7: taken branch followed by a dependent and three more
    send(8'h50, 5'd25, 5'd20, 5'd21, 1'b1, 16'h1234, ok);
    send(8'h51, 5'd26, 5'd25, 5'd21, 1'b0, '0, ok);
    for (int i = 2; i < 6; i++) send(8'h50 + 8'(i), 5'd27, 5'd20, 5'd21, 1'b0, '0, ok);
    check(lastRedirCycle == accCycle[8'h50] + 5, "R7", "redirect not delayed by stall",
          lastRedirCycle, accCycle[8'h50] + 5);
    idle(1);
    check(occAt[lastRedirCycle + 1] == 6'b100000, "R6", "occupancy after flush",
          occAt[lastRedirCycle + 1], 6'h20);
    send(8'h60, 5'd28, 5'd20, 5'd21, 1'b0, '0, ok);
    idle(12);
    check(retCycle[8'h50] == expRetire(accCycle[8'h50], 0), "R6", "branch retires",
          retCycle[8'h50], expRetire(accCycle[8'h50], 0));
    check(retCycle[8'h51] == -1, "R7", "stalled dependent discarded", retCycle[8'h51], -1);
    for (int i = 2; i < 5; i++)
      check(retCycle[8'h50 + i] == -1, "R6", "younger discarded", retCycle[8'h50 + i], -1);
    check(retCycle[8'h60] == expRetire(accCycle[8'h60], 0), "R6", "restart retires",
          retCycle[8'h60], expRetire(accCycle[8'h60], 0));
    check(sbQ.size() == 0, "R8", "queue empty after directed", sbQ.size(), 0);

    // Random mix: scoreboard checks order, discards and targets (R4 R6 R8)
    for (int n = 0; n < 400; n++) begin
      logic [REG_W-1:0] d, a, b;
      bit tk;
      d = 5'($urandom_range(0, 3));
      a = 5'($urandom_range(0, 3));
      b = 5'($urandom_range(0, 3));
      tk = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 5) == 0) idle(1);
      send(8'(n), d, a, b, tk, 16'($urandom), ok);
    end
    idle(20);
    check(sbQ.size() == 0, "R8", "all survivors retired", sbQ.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule